// File: doc/BRIEF.md
# Debug Address Comparator Unit

This block watches a processor's instruction fetch address and its data memory accesses against a small set of debug comparators. Breakpoint slots each hold an instruction address and an enable bit. Watchpoint slots each hold a byte address and a two-bit access type. When an enabled breakpoint matches the fetch address, the block requests a debug exception. When a watchpoint matches a data access, the block also requests a debug exception, and it withholds the access so that a matching store never reaches memory.

Software loads comparators one slot at a time through a write port. A slot is removed by clearing its enable bit or by writing the disabled type. A status vector keeps one bit per slot for each comparator that fired. It holds those bits until software clears them with a write-one-to-clear mask, so a handler can find the slot responsible. When a breakpoint and a watchpoint match in the same cycle, the breakpoint is reported first and the watchpoint follows in the next cycle.

Top module: `dbgm_unit`

## Requirements
- R1: After synchronous reset, `dbg_req` is 0, `dbg_cause` is 0 and `hit_status` is all zero. Every slot is disabled, so no fetch or access at any address (including 0) raises a request.
- R2: A fetch with `fetch_valid`=1 whose `fetch_pc` equals the address of an enabled breakpoint slot sets `dbg_req`=1 and `dbg_cause`=2'b01 in the following cycle.
- R3: A breakpoint slot written with `cfg_mode[0]`=0 is disabled and never matches.
- R4: Watchpoint type codes in `cfg_mode` are 2'b00 disabled, 2'b01 reads only, 2'b10 writes only and 2'b11 both. A read is an access with `mem_write`=0.
- R5: `mem_go` is combinational and equals `mem_valid` unless a watchpoint matches the access in the same cycle. In that case it is 0, so a matching store is not performed.
- R6: A watchpoint match with no breakpoint match in the same cycle sets `dbg_req`=1 and `dbg_cause`=2'b10 in the following cycle.
- R7: A watchpoint covers exactly one byte. An access at the slot address plus or minus one does not match.
- R8: When a breakpoint and a watchpoint match in the same cycle, the next cycle reports cause 2'b01. The watchpoint cause 2'b10 follows in the cycle after that unless another breakpoint matches first.
- R9: `hit_status` bit i (0..NUM_BP-1) is set by breakpoint slot i, and bit NUM_BP+j is set by watchpoint slot j. Bits stay set until a cycle with `stat_clr`=1 clears the bits marked in `stat_clr_mask`. A new hit in that same cycle wins over the clear.
- R10: With `cfg_we`=1, slot `cfg_idx` of the bank chosen by `cfg_is_wp` (0 breakpoint, 1 watchpoint) takes `cfg_addr` and `cfg_mode`. The new value takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Comparator slot write strobe |
| cfg_is_wp | input | 1 | 0 selects breakpoint bank, 1 watchpoint bank |
| cfg_idx | input | IDX_W | Slot index |
| cfg_addr | input | ADDR_W | Slot address |
| cfg_mode | input | 2 | Breakpoint enable in bit 0, or watchpoint type |
| stat_clr | input | 1 | Status clear strobe |
| stat_clr_mask | input | NUM_BP+NUM_WP | Write-one-to-clear mask for status |
| fetch_valid | input | 1 | Instruction fetch valid |
| fetch_pc | input | ADDR_W | Instruction fetch address |
| mem_valid | input | 1 | Data access request |
| mem_write | input | 1 | 1 for store, 0 for load |
| mem_addr | input | ADDR_W | Data byte address |
| mem_go | output | 1 | Access allowed to proceed this cycle |
| dbg_req | output | 1 | Debug exception request (registered) |
| dbg_cause | output | 2 | 01 breakpoint, 10 watchpoint, 00 none |
| hit_status | output | NUM_BP+NUM_WP | Sticky per-slot hit flags |

## Verification
A breakpoint match on the fetch port and a watchpoint match on the data port can occur in the same cycle. The bench provokes this by presenting an armed fetch address and an armed load address together. It then expects a breakpoint cause in the next cycle and a watchpoint cause in the cycle after. In both cycles it checks that the access was withheld and that both status bits were captured. A status clear that coincides with a fresh hit is also driven, and the bench judges that the new hit survives.

// File: rtl/dbgm_pkg.sv
package dbgm_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_BP   = 2'b01,
    CAUSE_WP   = 2'b10
  } cause_e;

  typedef enum logic [1:0] {
    WPT_OFF  = 2'b00,
    WPT_RD   = 2'b01,
    WPT_WR   = 2'b10,
    WPT_RDWR = 2'b11
  } wp_type_e;

endpackage

// File: rtl/dbgm_bp_bank.sv
module dbgm_bp_bank #(
  parameter int NUM    = 4,
  parameter int ADDR_W = 32,
  parameter int IW     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_enable,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic [NUM-1:0]    hit
);

  logic [ADDR_W-1:0] addr_q [NUM];
  logic [NUM-1:0]    en_q;

  for (genvar i = 0; i < NUM; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        addr_q[i] <= '0;
        en_q[i]   <= 1'b0;
      end else if (wr_en && (wr_idx == IW'(i))) begin
        addr_q[i] <= wr_addr;
        en_q[i]   <= wr_enable;
      end
    end

    assign hit[i] = fetch_valid && en_q[i] && (addr_q[i] == fetch_pc);

    // R3: a disabled slot never reports a hit
    a_r3_disabled_silent: assert property (@(posedge clk) disable iff (rst)
      !en_q[i] |-> !hit[i]);
    // R2: a hit only appears for a fetch at the stored address
    a_r2_addr_match: assert property (@(posedge clk) disable iff (rst)
      hit[i] |-> (fetch_valid && fetch_pc == addr_q[i]));
  end

endmodule

// File: rtl/dbgm_wp_bank.sv
module dbgm_wp_bank
  import dbgm_pkg::*;
#(
  parameter int NUM    = 4,
  parameter int ADDR_W = 32,
  parameter int IW     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_type,
  input  logic              mem_valid,
  input  logic              mem_write,
  input  logic [ADDR_W-1:0] mem_addr,
  output logic [NUM-1:0]    hit
);

  logic [ADDR_W-1:0] addr_q [NUM];
  wp_type_e          type_q [NUM];

  for (genvar i = 0; i < NUM; i++) begin : g_slot
    logic kind_ok;

    always_ff @(posedge clk) begin
      if (rst) begin
        addr_q[i] <= '0;
        type_q[i] <= WPT_OFF;
      end else if (wr_en && (wr_idx == IW'(i))) begin
        addr_q[i] <= wr_addr;
        type_q[i] <= wp_type_e'(wr_type);
      end
    end

    always_comb begin
      unique case (type_q[i])
        WPT_RD:   kind_ok = !mem_write;
        WPT_WR:   kind_ok = mem_write;
        WPT_RDWR: kind_ok = 1'b1;
        default:  kind_ok = 1'b0;
      endcase
    end

    assign hit[i] = mem_valid && kind_ok && (addr_q[i] == mem_addr);

    // R4: the disabled type never matches
    a_r4_off_silent: assert property (@(posedge clk) disable iff (rst)
      (type_q[i] == WPT_OFF) |-> !hit[i]);
    // R7: a hit needs the exact byte address
    a_r7_exact_byte: assert property (@(posedge clk) disable iff (rst)
      hit[i] |-> (mem_addr == addr_q[i]));
  end

endmodule

// File: rtl/dbgm_arbiter.sv
module dbgm_arbiter
  import dbgm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bp_any,
  input  logic       wp_any,
  output logic       dbg_req,
  output logic [1:0] dbg_cause
);

  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dbg_req   <= 1'b0;
      dbg_cause <= CAUSE_NONE;
      pend_q    <= 1'b0;
    end else if (bp_any) begin
      dbg_req   <= 1'b1;
      dbg_cause <= CAUSE_BP;
      pend_q    <= pend_q | wp_any;
    end else if (wp_any || pend_q) begin
      dbg_req   <= 1'b1;
      dbg_cause <= CAUSE_WP;
      pend_q    <= 1'b0;
    end else begin
      dbg_req   <= 1'b0;
      dbg_cause <= CAUSE_NONE;
    end
  end

  // R2: breakpoint match gives breakpoint cause next cycle
  a_r2_bp_cause: assert property (@(posedge clk) disable iff (rst)
    bp_any |=> (dbg_req && dbg_cause == CAUSE_BP));
  // R6: lone watchpoint match gives watchpoint cause next cycle
  a_r6_wp_cause: assert property (@(posedge clk) disable iff (rst)
    (wp_any && !bp_any) |=> (dbg_req && dbg_cause == CAUSE_WP));
  // R8: a deferred watchpoint is reported once no breakpoint competes
  a_r8_deferred: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !bp_any) |=> (dbg_cause == CAUSE_WP));
  a_r8_cause_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dbg_cause));

endmodule

// File: rtl/dbgm_unit.sv
module dbgm_unit #(
  parameter int NUM_BP = 4,
  parameter int NUM_WP = 4,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = ((NUM_BP > NUM_WP ? NUM_BP : NUM_WP) > 1) ?
                         $clog2(NUM_BP > NUM_WP ? NUM_BP : NUM_WP) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic                     cfg_is_wp,
  input  logic [IDX_W-1:0]         cfg_idx,
  input  logic [ADDR_W-1:0]        cfg_addr,
  input  logic [1:0]               cfg_mode,
  input  logic                     stat_clr,
  input  logic [NUM_BP+NUM_WP-1:0] stat_clr_mask,
  input  logic                     fetch_valid,
  input  logic [ADDR_W-1:0]        fetch_pc,
  input  logic                     mem_valid,
  input  logic                     mem_write,
  input  logic [ADDR_W-1:0]        mem_addr,
  output logic                     mem_go,
  output logic                     dbg_req,
  output logic [1:0]               dbg_cause,
  output logic [NUM_BP+NUM_WP-1:0] hit_status
);

  localparam int STAT_W = NUM_BP + NUM_WP;

  logic [NUM_BP-1:0] bp_hit;
  logic [NUM_WP-1:0] wp_hit;
  logic [STAT_W-1:0] stat_q;

  dbgm_bp_bank #(.NUM(NUM_BP), .ADDR_W(ADDR_W), .IW(IDX_W)) u_bp (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (cfg_we && !cfg_is_wp),
    .wr_idx     (cfg_idx),
    .wr_addr    (cfg_addr),
    .wr_enable  (cfg_mode[0]),
    .fetch_valid(fetch_valid),
    .fetch_pc   (fetch_pc),
    .hit        (bp_hit)
  );

  dbgm_wp_bank #(.NUM(NUM_WP), .ADDR_W(ADDR_W), .IW(IDX_W)) u_wp (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cfg_we && cfg_is_wp),
    .wr_idx   (cfg_idx),
    .wr_addr  (cfg_addr),
    .wr_type  (cfg_mode),
    .mem_valid(mem_valid),
    .mem_write(mem_write),
    .mem_addr (mem_addr),
    .hit      (wp_hit)
  );

  dbgm_arbiter u_arb (
    .clk      (clk),
    .rst      (rst),
    .bp_any   (|bp_hit),
    .wp_any   (|wp_hit),
    .dbg_req  (dbg_req),
    .dbg_cause(dbg_cause)
  );

  assign mem_go = mem_valid && (wp_hit == '0);

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= (stat_q & ~(stat_clr ? stat_clr_mask : '0)) | {wp_hit, bp_hit};
  end

  assign hit_status = stat_q;

  // R1: reset leaves no request and an empty status
  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (!dbg_req && hit_status == '0));
  // R5: a watchpoint-matched store never proceeds
  a_r5_store_held: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_write && wp_hit != '0) |-> !mem_go);
  // R9: without a clear, status bits only accumulate
  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    !stat_clr |=> ((hit_status & $past(hit_status)) == $past(hit_status)));

endmodule

// File: tb/dbgm_unit_bench.sv
module dbgm_unit_bench;
  localparam int NB = 4, NW = 4, AW = 32, IW = 2, SW = NB + NW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, cfg_we, cfg_is_wp, stat_clr, fetch_valid, mem_valid, mem_write;
  logic [IW-1:0] cfg_idx;
  logic [AW-1:0] cfg_addr, fetch_pc, mem_addr;
  logic [1:0] cfg_mode, dbg_cause;
  logic [SW-1:0] stat_clr_mask, hit_status;
  logic mem_go, dbg_req;

  dbgm_unit #(.NUM_BP(NB), .NUM_WP(NW), .ADDR_W(AW)) u_dbgm_unit (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_is_wp(cfg_is_wp), .cfg_idx(cfg_idx),
    .cfg_addr(cfg_addr), .cfg_mode(cfg_mode), .stat_clr(stat_clr),
    .stat_clr_mask(stat_clr_mask), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_go(mem_go), .dbg_req(dbg_req), .dbg_cause(dbg_cause), .hit_status(hit_status)
  );

  int n_chk = 0, n_bad = 0;
  logic [SW+2:0] exp_q[$];
  string tag_q[$];

  // reference model built from the requirements
  logic [AW-1:0] m_bpa [NB];
  logic          m_bpe [NB];
  logic [AW-1:0] m_wpa [NW];
  logic [1:0]    m_wpt [NW];
  logic [SW-1:0] m_st;
  logic          m_pend;

  task automatic cyc(input logic fv, input logic [AW-1:0] pc, input logic mv, input logic mw,
                     input logic [AW-1:0] ma, input logic cw, input logic ck,
                     input logic [IW-1:0] ci, input logic [AW-1:0] ca, input logic [1:0] cm,
                     input logic sc, input logic [SW-1:0] sm, input string tag);
    logic [NB-1:0] bh;
    logic [NW-1:0] wh;
    logic er, eg;
    logic [1:0] ec;
    @(negedge clk);
    fetch_valid = fv; fetch_pc = pc; mem_valid = mv; mem_write = mw; mem_addr = ma;
    cfg_we = cw; cfg_is_wp = ck; cfg_idx = ci; cfg_addr = ca; cfg_mode = cm;
    stat_clr = sc; stat_clr_mask = sm;
    bh = '0; wh = '0;
    for (int i = 0; i < NB; i++) bh[i] = fv && m_bpe[i] && (m_bpa[i] == pc);
    for (int j = 0; j < NW; j++)
      wh[j] = mv && (m_wpa[j] == ma) && (mw ? m_wpt[j][1] : m_wpt[j][0]);
    eg = mv && (wh == '0);
    #1;
    n_chk++;
    if (mem_go !== eg) begin
      n_bad++;
      $display("FAIL %s: mem_go=%0b expected %0b", tag, mem_go, eg);
    end
    if (bh != '0) begin
      er = 1'b1; ec = 2'b01; m_pend = m_pend | (wh != '0);
    end else if (wh != '0 || m_pend) begin
      er = 1'b1; ec = 2'b10; m_pend = 1'b0;
    end else begin
      er = 1'b0; ec = 2'b00;
    end
    m_st = (m_st & ~(sc ? sm : '0)) | {wh, bh};
    exp_q.push_back({er, ec, m_st});
    tag_q.push_back(tag);
    if (cw && !ck) begin m_bpa[ci] = ca; m_bpe[ci] = cm[0]; end
    if (cw && ck)  begin m_wpa[ci] = ca; m_wpt[ci] = cm; end
  endtask

  task automatic idle(input string tag);
    cyc(0, '0, 0, 0, '0, 0, 0, '0, '0, '0, 0, '0, tag);
  endtask
  task automatic fetch(input logic [AW-1:0] pc, input string tag);
    cyc(1, pc, 0, 0, '0, 0, 0, '0, '0, '0, 0, '0, tag);
  endtask
  task automatic access(input logic w, input logic [AW-1:0] a, input string tag);
    cyc(0, '0, 1, w, a, 0, 0, '0, '0, '0, 0, '0, tag);
  endtask
  task automatic set_slot(input logic wp, input logic [IW-1:0] i, input logic [AW-1:0] a,
                          input logic [1:0] m, input string tag);
    cyc(0, '0, 0, 0, '0, 1, wp, i, a, m, 0, '0, tag);
  endtask
  task automatic clear(input logic [SW-1:0] m, input string tag);
    cyc(0, '0, 0, 0, '0, 0, 0, '0, '0, '0, 1, m, tag);
  endtask

  // monitor: compares registered outputs against the scoreboard
  initial begin
    logic [SW+2:0] e;
    string t;
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if ({dbg_req, dbg_cause, hit_status} !== e) begin
          n_bad++;
          $display("FAIL %s: req=%0b cause=%b status=%b expected req=%0b cause=%b status=%b",
                   t, dbg_req, dbg_cause, hit_status, e[SW+2], e[SW+1:SW], e[SW-1:0]);
        end
      end
    end
  end

  bit done = 1'b0;
  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NB; i++) begin m_bpa[i] = '0; m_bpe[i] = 1'b0; end
    for (int j = 0; j < NW; j++) begin m_wpa[j] = '0; m_wpt[j] = 2'b00; end
    m_st = '0; m_pend = 1'b0;
    rst = 1'b1; cfg_we = 0; cfg_is_wp = 0; cfg_idx = '0; cfg_addr = '0; cfg_mode = '0;
    stat_clr = 0; stat_clr_mask = '0; fetch_valid = 0; fetch_pc = '0;
    mem_valid = 0; mem_write = 0; mem_addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    n_chk++;
    if (dbg_req !== 1'b0 || dbg_cause !== 2'b00 || hit_status !== '0 || mem_go !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset: req=%0b cause=%b status=%b go=%0b expected 0 00 0 0",
               dbg_req, dbg_cause, hit_status, mem_go);
    end
    fetch(32'h0, "R1 fetch at 0 after reset");
    access(1'b1, 32'h0, "R1 store at 0 after reset");

    set_slot(0, 2'd0, 32'h100, 2'b01, "R10 load bp0");
    set_slot(0, 2'd1, 32'h200, 2'b00, "R10 load bp1 disabled");
    fetch(32'h100, "R2 bp0 hit");
    fetch(32'h200, "R3 disabled bp1");
    fetch(32'h104, "R2 no hit other pc");
    clear('1, "R9 clear all");

    set_slot(1, 2'd0, 32'h1000, 2'b01, "R10 wp0 read");
    set_slot(1, 2'd1, 32'h2000, 2'b10, "R10 wp1 write");
    set_slot(1, 2'd2, 32'h3000, 2'b11, "R10 wp2 any");
    set_slot(1, 2'd3, 32'h4000, 2'b00, "R10 wp3 off");
    access(1'b0, 32'h1000, "R4 R5 R6 read hits wp0");
    access(1'b1, 32'h1000, "R4 write ignored by wp0");
    access(1'b1, 32'h2000, "R5 store held by wp1");
    access(1'b0, 32'h2000, "R4 read ignored by wp1");
    access(1'b0, 32'h3000, "R4 wp2 read");
    access(1'b1, 32'h3000, "R4 wp2 write");
    access(1'b0, 32'h4000, "R4 wp3 disabled");
    access(1'b0, 32'h1001, "R7 byte above");
    access(1'b0, 32'h0FFF, "R7 byte below");
    clear(8'h0F, "R9 partial clear");
    cyc(0, '0, 1, 0, 32'h1000, 0, 0, '0, '0, '0, 1, 8'hFF, "R9 hit wins clear");
    clear('1, "R9 clear all again");

    cyc(1, 32'h100, 1, 0, 32'h1000, 0, 0, '0, '0, '0, 0, '0, "R8 both same cycle");
    idle("R8 deferred watchpoint");
    idle("R8 quiet after");

    set_slot(0, 2'd0, 32'h100, 2'b00, "R10 remove bp0");
    fetch(32'h100, "R10 removed bp0 silent");
    set_slot(1, 2'd2, 32'h3000, 2'b00, "R10 remove wp2");
    access(1'b1, 32'h3000, "R10 removed wp2 silent");
    set_slot(0, 2'd3, 32'hFFFF_FFFC, 2'b01, "R10 load bp3");
    fetch(32'hFFFF_FFFC, "R2 bp3 high pc");
    idle("R2 end");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule